// File: doc/BRIEF.md
# Vector Element Load/Store Offset Generator

This unit turns the immediate field of a vectorised load or store into the immediate for one element of the vector. It first forms a linear element index from the element step and the sub-vector position. Loads take the source step and stores take the destination step. The unit then applies one of four addressing modes:

- plain, which passes the immediate through unchanged;
- unit-stride, which adds the index times the access width;
- element-stride, which multiplies by the index;
- shift, which multiplies by the index and then shifts left by an amount read from a register.

The unit has one register stage. The request is presented with `in_valid`, and the 32-bit immediate appears on the next clock edge together with a flag. The flag tells the issue logic that the decoded immediate must be replaced by the computed one. The register-file read, the address adder and the memory access are outside this unit.

Top module: `vls_imm_gen`

## Requirements
- R1: The element index is step × (sub_len + 1) + sub_step. When `op` = 1 (load) the step is `src_step`. When `op` = 2 (store) the step is `dst_step`.
- R2: When `op` is 0 or 3 (neither load nor store), the element index is zero. Element-stride then yields 0, and unit-stride yields the immediate alone.
- R3: When `ds_form` = 0 and `mode` is not 1, the immediate is `imm_field[15:0]` sign-extended to 32 bits.
- R4: When `ds_form` = 1 and `mode` is not 1, the immediate is `{imm_field[13:0], 2'b00}` taken as a 16-bit value and sign-extended.
- R5: When `mode` = 1 (shift), the immediate is `imm_field[10:0]` sign-extended. The result is (immediate × index) shifted left by `shift_reg`, truncated to 32 bits, and `replace_out` = 1.
- R6: In shift mode, a `shift_reg` value above 63 gives a result of zero.
- R7: When `mode` = 2 (unit-stride), the result is immediate + index × `acc_width`, truncated to 32 bits, and `replace_out` = 1.
- R8: When `mode` = 3 (element-stride), the result is immediate × index, truncated to 32 bits, and `replace_out` = 1.
- R9: When `mode` = 0 (plain), `replace_out` = 0 and the result is the sign-extended immediate of R3/R4, with no rescaling.
- R10: When `replace_out` = 1 and `ds_form` = 1, the 32-bit result is shifted right logically by 2 before it is output.
- R11: A request accepted with `in_valid` appears on `imm_out`/`replace_out` one clock later, with `out_valid` = 1. Without `in_valid`, `out_valid` = 0 and the data outputs hold their value. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| imm_field | input | 16 | Raw immediate bits from the instruction |
| ds_form | input | 1 | 1 = word-scaled form (14-bit field × 4) |
| mode | input | 2 | 0 plain, 1 shift, 2 unit-stride, 3 element-stride |
| op | input | 2 | 1 load, 2 store, 0/3 other |
| src_step | input | 7 | Source element step |
| dst_step | input | 7 | Destination element step |
| sub_step | input | 2 | Position inside the sub-vector |
| sub_len | input | 2 | Sub-vector length minus one |
| acc_width | input | 4 | Access width in bytes |
| shift_reg | input | 64 | Register value giving the shift amount |
| out_valid | output | 1 | Result present |
| imm_out | output | 32 | Replacement immediate |
| replace_out | output | 1 | Replacement applies |

## Verification
Directed requests cover each mode paired with each form. Negative immediates separate sign extension of the 16-bit field from sign extension of the 11-bit field. Loads and stores are given unequal source and destination steps, which shows which step was chosen, and a no-op request shows that the index is forced to zero. Shift amounts of 31, 32, 64 and a very large value probe truncation and the zero rule. Many random requests cross all fields and separate wrong sub-vector arithmetic from wrong rescaling.

// File: rtl/vls_imm_pkg.sv
package vls_imm_pkg;
  typedef enum logic [1:0] {
    AM_PLAIN = 2'd0,
    AM_SHIFT = 2'd1,
    AM_UNIT  = 2'd2,
    AM_ELEM  = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    MOP_NONE  = 2'd0,
    MOP_LOAD  = 2'd1,
    MOP_STORE = 2'd2,
    MOP_RSVD  = 2'd3
  } mem_op_e;

  localparam int unsigned SHAMT_W = 6;
endpackage

// File: rtl/vls_elem_index.sv
module vls_elem_index
  import vls_imm_pkg::*;
#(
  parameter int unsigned STEP_W = 7,
  parameter int unsigned SUB_W  = 2,
  localparam int unsigned OFF_W = STEP_W + SUB_W
) (
  input  logic [1:0]        op,
  input  logic [STEP_W-1:0] src_step,
  input  logic [STEP_W-1:0] dst_step,
  input  logic [SUB_W-1:0]  sub_step,
  input  logic [SUB_W-1:0]  sub_len,
  output logic [OFF_W-1:0]  elem_off,
  output logic              op_active
);
  function automatic logic [OFF_W-1:0] linear_index(
    input logic [STEP_W-1:0] step,
    input logic [SUB_W-1:0]  len_m1,
    input logic [SUB_W-1:0]  pos
  );
    logic [OFF_W-1:0] group;
    group = OFF_W'(step) << 0;
    return OFF_W'(group * (OFF_W'(len_m1) + OFF_W'(1))) + OFF_W'(pos);
  endfunction

  mem_op_e          op_e;
  logic [STEP_W-1:0] sel_step;

  always_comb begin
    op_e      = mem_op_e'(op);
    op_active = 1'b1;
    sel_step  = '0;
    unique case (op_e)
      MOP_LOAD:  sel_step = src_step;
      MOP_STORE: sel_step = dst_step;
      default:   op_active = 1'b0;
    endcase
    elem_off = op_active ? linear_index(sel_step, sub_len, sub_step) : '0;
  end
endmodule

// File: rtl/vls_imm_extract.sv
module vls_imm_extract
  import vls_imm_pkg::*;
#(
  parameter int unsigned IMM_W = 32
) (
  input  logic [15:0]      imm_field,
  input  logic             ds_form,
  input  logic             shift_mode,
  output logic [IMM_W-1:0] imm_sext
);
  function automatic logic [IMM_W-1:0] sext16(input logic [15:0] v);
    return {{(IMM_W-16){v[15]}}, v};
  endfunction

  function automatic logic [IMM_W-1:0] sext11(input logic [10:0] v);
    return {{(IMM_W-11){v[10]}}, v};
  endfunction

  always_comb begin
    if (shift_mode)    imm_sext = sext11(imm_field[10:0]);
    else if (ds_form)  imm_sext = sext16({imm_field[13:0], 2'b00});
    else               imm_sext = sext16(imm_field);
  end
endmodule

// File: rtl/vls_imm_combine.sv
module vls_imm_combine
  import vls_imm_pkg::*;
#(
  parameter int unsigned IMM_W = 32,
  parameter int unsigned OFF_W = 9,
  parameter int unsigned WID_W = 4,
  parameter int unsigned REG_W = 64
) (
  input  logic [1:0]       mode,
  input  logic             ds_form,
  input  logic [IMM_W-1:0] imm_sext,
  input  logic [OFF_W-1:0] elem_off,
  input  logic [WID_W-1:0] acc_width,
  input  logic [REG_W-1:0] shift_reg,
  output logic [IMM_W-1:0] result,
  output logic             replace,
  output logic             shift_oob
);
  logic [SHAMT_W-1:0] shamt;

  generate
    if (REG_W > SHAMT_W) begin : g_wide_reg
      assign shift_oob = |shift_reg[REG_W-1:SHAMT_W];
      assign shamt     = shift_reg[SHAMT_W-1:0];
    end else begin : g_narrow_reg
      assign shift_oob = 1'b0;
      assign shamt     = SHAMT_W'(shift_reg);
    end
  endgenerate

  function automatic logic [IMM_W-1:0] scaled(
    input logic [IMM_W-1:0] imm,
    input logic [OFF_W-1:0] off
  );
    return imm * IMM_W'(off);
  endfunction

  function automatic logic [IMM_W-1:0] strided(
    input logic [IMM_W-1:0] imm,
    input logic [OFF_W-1:0] off,
    input logic [WID_W-1:0] w
  );
    return imm + IMM_W'(off) * IMM_W'(w);
  endfunction

  function automatic logic [IMM_W-1:0] shifted(
    input logic [IMM_W-1:0]   imm,
    input logic [OFF_W-1:0]   off,
    input logic [SHAMT_W-1:0] sa,
    input logic               oob
  );
    logic [2*IMM_W-1:0] wide;
    wide = {{IMM_W{1'b0}}, scaled(imm, off)} << sa;
    return oob ? '0 : wide[IMM_W-1:0];
  endfunction

  addr_mode_e       mode_e;
  logic [IMM_W-1:0] raw;

  always_comb begin
    mode_e  = addr_mode_e'(mode);
    replace = 1'b1;
    unique case (mode_e)
      AM_SHIFT: raw = shifted(imm_sext, elem_off, shamt, shift_oob);
      AM_UNIT:  raw = strided(imm_sext, elem_off, acc_width);
      AM_ELEM:  raw = scaled(imm_sext, elem_off);
      default: begin
        raw     = imm_sext;
        replace = 1'b0;
      end
    endcase
    result = (replace && ds_form) ? (raw >> 2) : raw;
  end
endmodule

// File: rtl/vls_imm_gen.sv
module vls_imm_gen
  import vls_imm_pkg::*;
#(
  parameter int unsigned STEP_W = 7,
  parameter int unsigned SUB_W  = 2,
  parameter int unsigned WID_W  = 4,
  parameter int unsigned REG_W  = 64,
  parameter int unsigned IMM_W  = 32,
  localparam int unsigned OFF_W = STEP_W + SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [15:0]       imm_field,
  input  logic              ds_form,
  input  logic [1:0]        mode,
  input  logic [1:0]        op,
  input  logic [STEP_W-1:0] src_step,
  input  logic [STEP_W-1:0] dst_step,
  input  logic [SUB_W-1:0]  sub_step,
  input  logic [SUB_W-1:0]  sub_len,
  input  logic [WID_W-1:0]  acc_width,
  input  logic [REG_W-1:0]  shift_reg,
  output logic              out_valid,
  output logic [IMM_W-1:0]  imm_out,
  output logic              replace_out
);
  logic [OFF_W-1:0] elem_off;
  logic             op_active;
  logic [IMM_W-1:0] imm_sext;
  logic [IMM_W-1:0] result;
  logic             replace;
  logic             shift_oob;

  vls_elem_index #(.STEP_W(STEP_W), .SUB_W(SUB_W)) u_index (
    .op        (op),
    .src_step  (src_step),
    .dst_step  (dst_step),
    .sub_step  (sub_step),
    .sub_len   (sub_len),
    .elem_off  (elem_off),
    .op_active (op_active)
  );

  vls_imm_extract #(.IMM_W(IMM_W)) u_extract (
    .imm_field  (imm_field),
    .ds_form    (ds_form),
    .shift_mode (mode == 2'(AM_SHIFT)),
    .imm_sext   (imm_sext)
  );

  vls_imm_combine #(
    .IMM_W(IMM_W), .OFF_W(OFF_W), .WID_W(WID_W), .REG_W(REG_W)
  ) u_combine (
    .mode      (mode),
    .ds_form   (ds_form),
    .imm_sext  (imm_sext),
    .elem_off  (elem_off),
    .acc_width (acc_width),
    .shift_reg (shift_reg),
    .result    (result),
    .replace   (replace),
    .shift_oob (shift_oob)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      imm_out     <= '0;
      replace_out <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        imm_out     <= result;
        replace_out <= replace;
      end
    end
  end

  // R2: a request that is neither load nor store carries a zero index
  assert_noop_zero_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_active |-> elem_off == '0);

  // R5, R7, R8: strided and shift modes flag a replacement
  assert_strided_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode != 2'(AM_PLAIN) |=> replace_out);

  // R9: plain mode never flags
  assert_plain_noflag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == 2'(AM_PLAIN) |=> !replace_out);

  // R6: out-of-range shift amount zeroes the result
  assert_bigshift_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == 2'(AM_SHIFT) && shift_oob |=> imm_out == '0);

  // R10: rescaled results have two clear top bits
  assert_ds_rescale_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ds_form && mode != 2'(AM_PLAIN) |=> imm_out[IMM_W-1:IMM_W-2] == 2'b00);

  // R11: valid follows the request by one cycle; data holds when idle
  assert_valid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(imm_out) && $stable(replace_out));
endmodule

// File: tb/vls_imm_gen_tb_top.sv
module vls_imm_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] imm_field = '0;
  logic        ds_form = 1'b0;
  logic [1:0]  mode = '0;
  logic [1:0]  op = '0;
  logic [6:0]  src_step = '0;
  logic [6:0]  dst_step = '0;
  logic [1:0]  sub_step = '0;
  logic [1:0]  sub_len = '0;
  logic [3:0]  acc_width = '0;
  logic [63:0] shift_reg = '0;
  logic        out_valid;
  logic [31:0] imm_out;
  logic        replace_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] imm;
    logic        flag;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  vls_imm_gen dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .imm_field(imm_field),
    .ds_form(ds_form), .mode(mode), .op(op), .src_step(src_step),
    .dst_step(dst_step), .sub_step(sub_step), .sub_len(sub_len),
    .acc_width(acc_width), .shift_reg(shift_reg), .out_valid(out_valid),
    .imm_out(imm_out), .replace_out(replace_out)
  );

  // independent reference, written from the requirements in 64-bit integers
  function automatic exp_t model(
    input logic [15:0] f, input logic ds, input logic [1:0] md,
    input logic [1:0] o, input logic [6:0] s, input logic [6:0] d,
    input logic [1:0] ss, input logic [1:0] sl, input logic [3:0] w,
    input logic [63:0] sh, input string tag
  );
    exp_t e;
    longint iv, idx, r;
    if (md == 2'd1) iv = longint'($signed(f[10:0]));
    else if (ds)    iv = longint'($signed({f[13:0], 2'b00}));
    else            iv = longint'($signed(f));
    if (o == 2'd1)      idx = longint'(s) * (longint'(sl) + 1) + longint'(ss);
    else if (o == 2'd2) idx = longint'(d) * (longint'(sl) + 1) + longint'(ss);
    else                idx = 0;
    e.flag = (md != 2'd0);
    case (md)
      2'd1:    r = (sh > 64'd63) ? 0 : ((iv * idx) << sh[5:0]);
      2'd2:    r = iv + idx * longint'(w);
      2'd3:    r = iv * idx;
      default: r = iv;
    endcase
    e.imm = r[31:0];
    if (e.flag && ds) e.imm = e.imm >> 2;
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(
    input string tag, input logic [15:0] f, input logic ds, input logic [1:0] md,
    input logic [1:0] o, input logic [6:0] s, input logic [6:0] d,
    input logic [1:0] ss, input logic [1:0] sl, input logic [3:0] w,
    input logic [63:0] sh
  );
    @(negedge clk);
    in_valid = 1'b1; imm_field = f; ds_form = ds; mode = md; op = o;
    src_step = s; dst_step = d; sub_step = ss; sub_len = sl;
    acc_width = w; shift_reg = sh;
    exp_q.push_back(model(f, ds, md, o, s, d, ss, sl, w, sh, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops one expected item per valid output
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R11 unexpected output actual=%h expected=none", imm_out);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        last_exp = e;
        if (imm_out !== e.imm || replace_out !== e.flag) begin
          failures++;
          $display("FAIL %s actual=%h/%b expected=%h/%b",
                   e.tag, imm_out, replace_out, e.imm, e.flag);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    checks++;
    if (out_valid !== 1'b0 || imm_out !== 32'h0 || replace_out !== 1'b0) begin
      failures++;
      $display("FAIL R11 reset actual=%b/%h/%b expected=0/0/0",
               out_valid, imm_out, replace_out);
    end
    rst_n = 1'b1;

    drive("R3 plain D negative", 16'hFFF0, 0, 2'd0, 2'd1, 7'd3, 7'd9, 2'd0, 2'd0, 4'd4, 64'd0);
    drive("R4 plain DS", 16'h3FFF, 1, 2'd0, 2'd1, 7'd3, 7'd9, 2'd0, 2'd0, 4'd4, 64'd0);
    drive("R9 plain DS positive no rescale", 16'h0105, 1, 2'd0, 2'd2, 7'd1, 7'd2, 2'd1, 2'd1, 4'd8, 64'd0);
    drive("R1 load uses src", 16'd5, 0, 2'd3, 2'd1, 7'd3, 7'd9, 2'd1, 2'd1, 4'd4, 64'd0);
    drive("R1 store uses dst", 16'd5, 0, 2'd3, 2'd2, 7'd3, 7'd9, 2'd1, 2'd1, 4'd4, 64'd0);
    drive("R1 max index", 16'd1, 0, 2'd3, 2'd1, 7'd127, 7'd0, 2'd3, 2'd3, 4'd1, 64'd0);
    drive("R2 noop elem", 16'd77, 0, 2'd3, 2'd0, 7'd5, 7'd6, 2'd2, 2'd3, 4'd4, 64'd0);
    drive("R2 rsvd unit", 16'hFF00, 0, 2'd2, 2'd3, 7'd5, 7'd6, 2'd2, 2'd3, 4'd4, 64'd0);
    drive("R7 unit stride", 16'h0010, 0, 2'd2, 2'd1, 7'd4, 7'd0, 2'd0, 2'd0, 4'd8, 64'd0);
    drive("R8 elem negative", 16'hFFFE, 0, 2'd3, 2'd2, 7'd0, 7'd10, 2'd2, 2'd2, 4'd2, 64'd0);
    drive("R5 shift neg SVD", 16'h07FF, 0, 2'd1, 2'd1, 7'd2, 7'd0, 2'd0, 2'd0, 4'd1, 64'd4);
    drive("R5 shift 31", 16'h0003, 0, 2'd1, 2'd1, 7'd1, 7'd0, 2'd0, 2'd0, 4'd1, 64'd31);
    drive("R5 shift 32", 16'h0003, 0, 2'd1, 2'd1, 7'd1, 7'd0, 2'd0, 2'd0, 4'd1, 64'd32);
    drive("R6 shift 64", 16'h0003, 0, 2'd1, 2'd1, 7'd1, 7'd0, 2'd0, 2'd0, 4'd1, 64'd64);
    drive("R6 shift huge", 16'h0003, 0, 2'd1, 2'd1, 7'd1, 7'd0, 2'd0, 2'd0, 4'd1, 64'h0000_0100_0000_0001);
    drive("R10 unit DS", 16'h0004, 1, 2'd2, 2'd1, 7'd2, 7'd0, 2'd0, 2'd0, 4'd8, 64'd0);
    drive("R10 elem DS negative", 16'h3FFF, 1, 2'd3, 2'd1, 7'd3, 7'd0, 2'd0, 2'd0, 4'd8, 64'd0);
    idle(4);

    // R11 idle hold: outputs keep the last result while no request arrives
    checks++;
    if (out_valid !== 1'b0 || imm_out !== last_exp.imm || replace_out !== last_exp.flag) begin
      failures++;
      $display("FAIL R11 hold actual=%b/%h/%b expected=0/%h/%b",
               out_valid, imm_out, replace_out, last_exp.imm, last_exp.flag);
    end

    for (int n = 0; n < 400; n++) begin
      logic [63:0] sh;
      sh = ($urandom_range(0, 7) == 0) ? {$urandom(), $urandom()} : 64'($urandom_range(0, 40));
      drive("R1 random", 16'($urandom()), 1'($urandom()), 2'($urandom()), 2'($urandom()),
            7'($urandom()), 7'($urandom()), 2'($urandom()), 2'($urandom()),
            4'($urandom()), sh);
      if ($urandom_range(0, 5) == 0) idle(1);
    end
    idle(4);

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R11 missing outputs actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule